// File: doc/BRIEF.md
# Selectable-Network Adder/Subtractor

This block adds or subtracts two unsigned words of parameterised width in one combinational path. A run-time select chooses the operation. During addition the carry input is added. During subtraction it is taken away, so it acts as a borrow. The single-bit carry output is the top bit of the result one bit wider than the operands. During subtraction it becomes a borrow that is set when the difference would be negative.

Either carry pin can be set active low or active high at elaboration, or it can be marked unused. An unused carry input counts as zero, and an unused carry output is held at zero. A further parameter picks the internal carry network: ripple, carry-select, Sklansky prefix or Brent-Kung prefix. The choice trades logic depth against gate count and fan-out. Every network returns exactly the same sum and carry for the same inputs.

Top module: `addsub_prefix`

## Requirements
- R1: With `add_i` = 1, `sum_o` equals the low WIDTH bits of A + B + c, where c is the effective carry input (0 or 1).
- R2: With `add_i` = 0, `sum_o` equals the low WIDTH bits of A − B − c, so the effective carry input is a borrow.
- R3: With CO_POL = 1, `cout_o` is bit WIDTH of the WIDTH+1 bit result of the chosen operation on zero-extended operands. For subtraction this is 1 exactly when A < B + c.
- R4: CI_POL = 1 makes `cin_i` active high (c = `cin_i`), and CI_POL = 0 makes it active low (c = NOT `cin_i`).
- R5: CI_POL = 2 marks the carry input unused: c is 0 whatever `cin_i` holds.
- R6: CO_POL = 0 drives `cout_o` with the inverse of the R3 value.
- R7: CO_POL = 2 marks the carry output unused, and `cout_o` stays at 0.
- R8: NET selects the carry network: 0 ripple, 1 carry-select with blocks of SEL_BLK bits, 2 Sklansky prefix, 3 Brent-Kung prefix. All four give bit-identical `sum_o` and `cout_o`.
- R9: WIDTH may be any value from 2 to 128, including values that are not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend when subtracting) |
| b_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| add_i | input | 1 | 1 selects addition, 0 selects subtraction |
| cin_i | input | 1 | Carry in (add) or borrow in (subtract); polarity set by CI_POL |
| sum_o | output | WIDTH | Low WIDTH bits of the result |
| cout_o | output | 1 | Carry out (add) or borrow out (subtract); polarity set by CO_POL |

## Verification
The block holds no state, so any fault in the network shows up at the ports as soon as the inputs settle. A wrong generate or propagate term in a prefix node corrupts every sum bit above that node, and it can also corrupt the carry output. A carry-select block with a wrong select sends the wrong precomputed half to its bits, but only for inputs that carry into that block. For this reason, narrow widths are swept over every input, while wide widths get random operands plus long carry chains that run the full length of the word. A polarity slip inverts the carry or borrow on every vector where it matters. The bench compares each instance with an arithmetic model at every step, so such a slip is caught on the first affected vector.

// File: rtl/addsub_prefix.sv
module addsub_prefix #(
  parameter int WIDTH   = 32,
  parameter int CI_POL  = 1,
  parameter int CO_POL  = 1,
  parameter int NET     = 3,
  parameter int SEL_BLK = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             add_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int LVL  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int NBLK = (WIDTH + SEL_BLK - 1) / SEL_BLK;
  localparam int NST  = 2 * LVL - 1;

  logic             cin_eff;
  logic             c_first;
  logic             op_carry;
  logic             g_first;
  logic [WIDTH-1:0] bx, g, p;
  logic [WIDTH:0]   c;

  generate
    if (CI_POL == 2) begin : g_ci_off
      assign cin_eff = 1'b0;
    end else if (CI_POL == 0) begin : g_ci_low
      assign cin_eff = ~cin_i;
    end else begin : g_ci_high
      assign cin_eff = cin_i;
    end
  endgenerate

  assign c_first = add_i ? cin_eff : ~cin_eff;
  assign bx      = add_i ? b_i : ~b_i;
  assign g       = a_i & bx;
  assign p       = a_i ^ bx;
  assign g_first = g[0] | (p[0] & c_first);
  assign c[0]    = c_first;
  assign sum_o   = p ^ c[WIDTH-1:0];
  assign op_carry = add_i ? c[WIDTH] : ~c[WIDTH];

  generate
    if (CO_POL == 2) begin : g_co_off
      assign cout_o = 1'b0;
    end else if (CO_POL == 0) begin : g_co_low
      assign cout_o = ~op_carry;
    end else begin : g_co_high
      assign cout_o = op_carry;
    end
  endgenerate

  generate
    if (NET == 0) begin : g_ripple
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign c[i+1] = g[i] | (p[i] & c[i]);
      end

    end else if (NET == 1) begin : g_csel
      for (genvar blk = 0; blk < NBLK; blk++) begin : g_blk
        localparam int LO = blk * SEL_BLK;
        localparam int N  = (LO + SEL_BLK > WIDTH) ? (WIDTH - LO) : SEL_BLK;
        logic [N:0] k0, k1;
        assign k0[0] = 1'b0;
        assign k1[0] = 1'b1;
        for (genvar t = 0; t < N; t++) begin : g_bit
          assign k0[t+1]     = g[LO+t] | (p[LO+t] & k0[t]);
          assign k1[t+1]     = g[LO+t] | (p[LO+t] & k1[t]);
          assign c[LO+t+1]   = c[LO] ? k1[t+1] : k0[t+1];
        end
      end

    end else if (NET == 2) begin : g_sklansky
      logic [WIDTH-1:0] sg [0:LVL];
      logic [WIDTH-1:0] sp [0:LVL];
      assign sg[0] = {g[WIDTH-1:1], g_first};
      assign sp[0] = p;
      for (genvar k = 0; k < LVL; k++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
          if (((i >> k) & 1) == 1) begin : g_cmb
            localparam int J = ((i >> k) << k) - 1;
            assign sg[k+1][i] = sg[k][i] | (sp[k][i] & sg[k][J]);
            assign sp[k+1][i] = sp[k][i] & sp[k][J];
          end else begin : g_pass
            assign sg[k+1][i] = sg[k][i];
            assign sp[k+1][i] = sp[k][i];
          end
        end
      end
      assign c[WIDTH:1] = sg[LVL];

    end else begin : g_brent_kung
      logic [WIDTH-1:0] bg [0:NST];
      logic [WIDTH-1:0] bp [0:NST];
      assign bg[0] = {g[WIDTH-1:1], g_first};
      assign bp[0] = p;
      for (genvar s = 0; s < NST; s++) begin : g_stage
        localparam bit UP = (s < LVL);
        localparam int K  = UP ? s : (2 * LVL - 2 - s);
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
          localparam bit ACT = UP ? (((i + 1) % (1 << (K + 1))) == 0)
                                  : ((((i + 1) % (1 << (K + 1))) == (1 << K)) &&
                                     ((i + 1) > (1 << (K + 1))));
          if (ACT) begin : g_cmb
            localparam int J = i - (1 << K);
            assign bg[s+1][i] = bg[s][i] | (bp[s][i] & bg[s][J]);
            assign bp[s+1][i] = bp[s][i] & bp[s][J];
          end else begin : g_pass
            assign bg[s+1][i] = bg[s][i];
            assign bp[s+1][i] = bp[s][i];
          end
        end
      end
      assign c[WIDTH:1] = bg[NST];
    end
  endgenerate

  logic [WIDTH:0] ref_add, ref_sub;
  assign ref_add = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_eff};
  assign ref_sub = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, cin_eff};

  always_comb begin
    if (!$isunknown({a_i, b_i, add_i, cin_i})) begin
      if (add_i) begin
        assert_add_sum_R1: assert (sum_o == ref_add[WIDTH-1:0])
          else $error("sum mismatch on add");
      end else begin
        assert_sub_sum_R2: assert (sum_o == ref_sub[WIDTH-1:0])
          else $error("sum mismatch on subtract");
      end
      if (CO_POL == 1) begin
        assert_cout_high_R3: assert (cout_o == (add_i ? ref_add[WIDTH] : ref_sub[WIDTH]))
          else $error("carry/borrow out mismatch");
      end
      if (CO_POL == 0) begin
        assert_cout_low_R6: assert (cout_o != (add_i ? ref_add[WIDTH] : ref_sub[WIDTH]))
          else $error("active-low carry out mismatch");
      end
      if (CO_POL == 2) begin
        assert_cout_unused_R7: assert (cout_o == 1'b0)
          else $error("unused carry out not zero");
      end
    end
  end

endmodule

// File: tb/addsub_prefix_tb.sv
module addsub_prefix_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0]   as, bs;
  logic [60:0]  al, bl;
  logic [127:0] ah, bh;
  logic         add, cin;

  logic [4:0]   s_s [6];
  logic         c_s [6];
  logic [60:0]  s_l [4];
  logic         c_l [4];
  logic [127:0] s_h [2];
  logic         c_h [2];

  int sm_cp [6] = '{1, 1, 1, 1, 0, 2};
  int sm_op [6] = '{1, 1, 1, 1, 0, 2};

  // narrow width 5: NET 0..3 plus polarity variants
  addsub_prefix #(.WIDTH(5), .CI_POL(1), .CO_POL(1), .NET(0)) u_dut_s0 (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[0]), .cout_o(c_s[0]));
  addsub_prefix #(.WIDTH(5), .CI_POL(1), .CO_POL(1), .NET(1), .SEL_BLK(2)) u_dut_s1 (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[1]), .cout_o(c_s[1]));
  addsub_prefix #(.WIDTH(5), .CI_POL(1), .CO_POL(1), .NET(2)) u_dut_s2 (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[2]), .cout_o(c_s[2]));
  addsub_prefix #(.WIDTH(5), .CI_POL(1), .CO_POL(1), .NET(3)) u_dut (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[3]), .cout_o(c_s[3]));
  addsub_prefix #(.WIDTH(5), .CI_POL(0), .CO_POL(0), .NET(3)) u_dut_s4 (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[4]), .cout_o(c_s[4]));
  addsub_prefix #(.WIDTH(5), .CI_POL(2), .CO_POL(2), .NET(1), .SEL_BLK(2)) u_dut_s5 (.a_i(as), .b_i(bs), .add_i(add), .cin_i(cin), .sum_o(s_s[5]), .cout_o(c_s[5]));

  // wide width 61 (not a power of two)
  addsub_prefix #(.WIDTH(61), .NET(0)) u_dut_l0 (.a_i(al), .b_i(bl), .add_i(add), .cin_i(cin), .sum_o(s_l[0]), .cout_o(c_l[0]));
  addsub_prefix #(.WIDTH(61), .NET(1), .SEL_BLK(8)) u_dut_l1 (.a_i(al), .b_i(bl), .add_i(add), .cin_i(cin), .sum_o(s_l[1]), .cout_o(c_l[1]));
  addsub_prefix #(.WIDTH(61), .NET(2)) u_dut_l2 (.a_i(al), .b_i(bl), .add_i(add), .cin_i(cin), .sum_o(s_l[2]), .cout_o(c_l[2]));
  addsub_prefix #(.WIDTH(61), .NET(3)) u_dut_l3 (.a_i(al), .b_i(bl), .add_i(add), .cin_i(cin), .sum_o(s_l[3]), .cout_o(c_l[3]));

  // maximum width 128
  addsub_prefix #(.WIDTH(128), .CI_POL(0), .CO_POL(0), .NET(3)) u_dut_h0 (.a_i(ah), .b_i(bh), .add_i(add), .cin_i(cin), .sum_o(s_h[0]), .cout_o(c_h[0]));
  addsub_prefix #(.WIDTH(128), .CI_POL(1), .CO_POL(1), .NET(2)) u_dut_h1 (.a_i(ah), .b_i(bh), .add_i(add), .cin_i(cin), .sum_o(s_h[1]), .cout_o(c_h[1]));

  int h_cp [2] = '{0, 1};
  int h_op [2] = '{0, 1};

  function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic ad, input logic ci,
                                         input int w, input int cp, input int op);
    logic [128:0] mask, full, r;
    logic ce, co;
    mask = (129'd1 << w) - 129'd1;
    ce = (cp == 2) ? 1'b0 : ((cp == 0) ? ~ci : ci);
    if (ad) full = {1'b0, a} + {1'b0, b} + {128'd0, ce};
    else    full = {1'b0, a} - {1'b0, b} - {128'd0, ce};
    co = full[w];
    if (op == 2)      co = 1'b0;
    else if (op == 0) co = ~co;
    r = full & mask;
    r[128] = co;
    return r;
  endfunction

  task automatic chk(input string req, input string who, input logic [128:0] got, input logic [128:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", req, who, got, exp);
    end
  endtask

  task automatic run_small(input logic [4:0] a, input logic [4:0] b, input logic ad, input logic ci);
    @(posedge clk);
    as = a; bs = b; add = ad; cin = ci;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      string req;
      if (i < 4)       req = ad ? "R1 R3 R8" : "R2 R3 R8";
      else if (i == 4) req = "R4 R6";
      else             req = "R5 R7";
      chk(req, $sformatf("w5 inst%0d", i), {c_s[i], 123'd0, s_s[i]},
          model({123'd0, a}, {123'd0, b}, ad, ci, 5, sm_cp[i], sm_op[i]));
    end
  endtask

  task automatic run_wide(input logic [127:0] a, input logic [127:0] b, input logic ad, input logic ci);
    @(posedge clk);
    al = a[60:0]; bl = b[60:0]; ah = a; bh = b; add = ad; cin = ci;
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk("R8 R9", $sformatf("w61 net%0d", i), {c_l[i], 67'd0, s_l[i]},
          model({67'd0, a[60:0]}, {67'd0, b[60:0]}, ad, ci, 61, 1, 1));
    for (int i = 0; i < 2; i++)
      chk("R9 R4 R6", $sformatf("w128 inst%0d", i), {c_h[i], s_h[i]},
          model(a, b, ad, ci, 128, h_cp[i], h_op[i]));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    as = '0; bs = '0; al = '0; bl = '0; ah = '0; bh = '0; add = 1'b1; cin = 1'b0;

    // idle vector: zero plus zero
    run_small(5'd0, 5'd0, 1'b1, 1'b0);

    // R1 R2 R4 R5: exhaustive sweep of the narrow width, all four mode/carry pairs
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          run_small(a[4:0], b[4:0], m[1], m[0]);

    // R3 R9: directed full-length carry and borrow chains
    run_wide({128{1'b1}}, 128'd0, 1'b1, 1'b1);
    run_wide({128{1'b1}}, 128'd1, 1'b1, 1'b0);
    run_wide(128'd0, 128'd0, 1'b0, 1'b1);
    run_wide(128'd0, 128'd0, 1'b0, 1'b0);
    run_wide(128'd5, 128'd5, 1'b0, 1'b1);
    run_wide({128{1'b1}}, {128{1'b1}}, 1'b0, 1'b0);
    run_wide({64{2'b10}}, {64{2'b01}}, 1'b1, 1'b1);

    // R8 R9: random wide operands
    for (int n = 0; n < 1500; n++) begin
      logic [127:0] ra, rb;
      ra = rnd128();
      rb = (n % 5 == 0) ? ~ra : rnd128();
      run_wide(ra, rb, $urandom() % 2 == 0, $urandom() % 2 == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule